// File: doc/BRIEF.md
# Boot Vector Remap Controller

This block selects where a processor subsystem finds its exception vectors and its boot code. A low address window, 32 KiB from address zero, is steered either to a boot ROM or to an on-chip SRAM. After power-up the window points at the ROM. Software can then set a remap bit so that the same addresses reach the SRAM, which makes the vector table writable. A separate high-vector bit tells the core whether its vectors sit at 0x00000000 or at 0xFFFF0000. That bit is loaded from a board strap pin during cold reset.

Two independent synchronous, active-high resets act on different registers. The bus reset clears the remap state and the error flag. The cold reset reloads the high-vector bit from the strap and clears an interrupt-configuration bit. High vectors and remap enabled together form a forbidden setting. Any write that would create it is refused and raises a sticky error flag. If a cold reset brings the high-vector bit up while remap is still set, the decoder gives way and sends the window to the ROM.

A small word-addressed register port gives software read and write access. The address decoder is registered: for each incoming address it produces a one-hot select and a pass-through copy of the address one cycle later.

Top module: `boot_remap_ctrl`

## Requirements
- R1: While `bus_rst` is high at a clock edge, the remap bit and the error flag clear, and after that edge all three select outputs and `reg_rdata` read zero.
- R2: While `cold_rst` is high at a clock edge, the high-vector bit takes the value of `strap_hivec` and the interrupt bit clears. A bus reset alone leaves both bits unchanged.
- R3: A cold reset alone does not change the remap bit.
- R4: An address below 0x8000 raises `rom_sel` one cycle later when the effective remap (remap AND NOT high-vector) is 0.
- R5: An address below 0x8000 raises `sram_sel` one cycle later when remap is 1 and high-vector is 0.
- R6: An address of 0x8000 or above raises `other_sel`. Outside reset, exactly one select is high. `mem_addr` equals the address that was presented one cycle earlier.
- R7: `vec_hi` equals the high-vector bit: 0 places the vectors at 0x00000000, 1 places them at 0xFFFF0000. `irq_cfg` equals the interrupt bit.
- R8: A write of 1 to the remap bit while the high-vector bit is 1 is ignored and sets the sticky error flag. A write of 1 to the high-vector bit while the remap bit is 1 is ignored in the same way. The flag is cleared only by the bus reset.
- R9: Register map, with the data in `reg_wdata[0]`: offset 0x0 holds remap in bit 0 and the error flag in bit 1 (read-only); offset 0x4 holds high-vector in bit 0; offset 0x8 holds the interrupt bit in bit 0. All other bits and all other offsets read zero, and writes to other offsets have no effect. `reg_rdata` shows the register chosen by `reg_addr` one cycle later, with the value it had before any write in that same cycle.
- R10: A write to the remap bit takes effect in the decoder for the address presented in the cycle after the write is accepted. The address presented in the same cycle as the write is still decoded with the old value.
- R11: When remap and high-vector are both 1 (reachable only through a cold reset), the vector window goes to the ROM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| bus_rst | input | 1 | Synchronous bus reset, active high |
| cold_rst | input | 1 | Synchronous cold reset, active high |
| strap_hivec | input | 1 | Board strap sampled into the high-vector bit during cold reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| bus_addr | input | ADDR_W | Address to decode |
| rom_sel | output | 1 | Boot ROM select |
| sram_sel | output | 1 | On-chip SRAM select |
| other_sel | output | 1 | Select for addresses outside the window |
| mem_addr | output | ADDR_W | Registered pass-through of bus_addr |
| vec_hi | output | 1 | Vector placement to the core (1 = high vectors) |
| irq_cfg | output | 1 | Interrupt configuration bit |
| remap_err | output | 1 | Sticky flag for a refused write |

## Verification
The assertions assume the two resets are only ever asserted for whole clock cycles. The remap-blocking property assumes the bus reset is low in the cycle after the refused write, because the flag would otherwise be cleared. The bench drives every input at the falling edge and raises each reset on its own for exactly one cycle. It never writes during a reset cycle. The mix of random writes and cold resets with a random strap value still reaches the state where remap and high-vector are both set.

// File: rtl/vrm_pkg.sv
package vrm_pkg;
  localparam int unsigned REG_AW = 4;

  localparam logic [REG_AW-1:0] OFS_REMAP = 4'h0;
  localparam logic [REG_AW-1:0] OFS_HIVEC = 4'h4;
  localparam logic [REG_AW-1:0] OFS_IRQ   = 4'h8;

  typedef struct packed {
    logic remap;
    logic hivec;
    logic irq;
    logic err;
  } ctrl_state_t;
endpackage

// File: rtl/vrm_regs.sv
module vrm_regs
  import vrm_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              bus_rst,
  input  logic              cold_rst,
  input  logic              strap_hivec,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output ctrl_state_t       st,
  output logic [DATA_W-1:0] rdata
);
  logic remap_q, hivec_q, irq_q, err_q;
  logic wr_remap, wr_hivec, wr_irq;
  logic unused_wbits;

  assign wr_remap = we && (addr == OFS_REMAP);
  assign wr_hivec = we && (addr == OFS_HIVEC);
  assign wr_irq   = we && (addr == OFS_IRQ);
  assign unused_wbits = ^wdata[DATA_W-1:1];

  // bus reset domain: remap bit and sticky error flag
  always_ff @(posedge clk) begin
    if (bus_rst) begin
      remap_q <= 1'b0;
      err_q   <= 1'b0;
    end else if (wr_remap) begin
      if (wdata[0] && hivec_q) err_q   <= 1'b1;
      else                     remap_q <= wdata[0];
    end else if (wr_hivec && wdata[0] && remap_q) begin
      err_q <= 1'b1;
    end
  end

  // cold reset domain: strap-loaded high-vector bit and interrupt bit
  always_ff @(posedge clk) begin
    if (cold_rst) begin
      hivec_q <= strap_hivec;
      irq_q   <= 1'b0;
    end else if (wr_hivec) begin
      if (!(wdata[0] && remap_q)) hivec_q <= wdata[0];
    end else if (wr_irq) begin
      irq_q <= wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (bus_rst) begin
      rdata <= '0;
    end else begin
      rdata <= '0;
      case (addr)
        OFS_REMAP: rdata[1:0] <= {err_q, remap_q};
        OFS_HIVEC: rdata[0]   <= hivec_q;
        OFS_IRQ:   rdata[0]   <= irq_q;
        default:   rdata      <= '0;
      endcase
    end
  end

  assign st = '{remap: remap_q, hivec: hivec_q, irq: irq_q, err: err_q};

  AST_REMAP_BLOCKED: assert property (@(posedge clk) disable iff (bus_rst)
    (wr_remap && wdata[0] && hivec_q && !cold_rst) |=> (err_q && $stable(remap_q))); // R8
  AST_COLD_LOADS_STRAP: assert property (@(posedge clk) disable iff (bus_rst)
    cold_rst |=> (hivec_q == $past(strap_hivec)) && !irq_q); // R2
  AST_BUS_KEEPS_HIVEC: assert property (@(posedge clk) disable iff (cold_rst)
    bus_rst |=> $stable(hivec_q)); // R2
  AST_COLD_KEEPS_REMAP: assert property (@(posedge clk) disable iff (bus_rst)
    (cold_rst && !wr_remap) |=> $stable(remap_q)); // R3
endmodule

// File: rtl/vrm_decode.sv
module vrm_decode #(
  parameter int unsigned ADDR_W   = 32,
  parameter logic [31:0] WIN_BASE = 32'h0000_0000,
  parameter logic [31:0] WIN_SIZE = 32'h0000_8000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              remap,
  input  logic              hivec,
  output logic              rom_sel,
  output logic              sram_sel,
  output logic              other_sel,
  output logic [ADDR_W-1:0] mem_addr
);
  localparam logic [ADDR_W-1:0] BASE_L = ADDR_W'(WIN_BASE);
  localparam logic [ADDR_W-1:0] SIZE_L = ADDR_W'(WIN_SIZE);

  logic [ADDR_W-1:0] offs;
  logic              in_win;
  logic              eff_remap;

  assign offs      = addr - BASE_L;
  assign in_win    = offs < SIZE_L;
  // the forbidden pair never steers to SRAM
  assign eff_remap = remap && !hivec;

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_sel   <= 1'b0;
      sram_sel  <= 1'b0;
      other_sel <= 1'b0;
      mem_addr  <= '0;
    end else begin
      rom_sel   <= in_win && !eff_remap;
      sram_sel  <= in_win && eff_remap;
      other_sel <= !in_win;
      mem_addr  <= addr;
    end
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $onehot({rom_sel, sram_sel, other_sel})); // R6
  AST_SRAM_NEEDS_LOWVEC: assert property (@(posedge clk) disable iff (rst)
    sram_sel |-> !$past(hivec) && $past(remap)); // R11
  AST_ADDR_PASS: assert property (@(posedge clk) disable iff (rst)
    !rst |=> mem_addr == $past(addr)); // R6
endmodule

// File: rtl/boot_remap_ctrl.sv
module boot_remap_ctrl
  import vrm_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DATA_W   = 32,
  parameter logic [31:0] WIN_BASE = 32'h0000_0000,
  parameter logic [31:0] WIN_SIZE = 32'h0000_8000
) (
  input  logic              clk,
  input  logic              bus_rst,
  input  logic              cold_rst,
  input  logic              strap_hivec,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              rom_sel,
  output logic              sram_sel,
  output logic              other_sel,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              vec_hi,
  output logic              irq_cfg,
  output logic              remap_err
);
  ctrl_state_t st;

  vrm_regs #(.DATA_W(DATA_W)) regs_i (
    .clk(clk), .bus_rst(bus_rst), .cold_rst(cold_rst), .strap_hivec(strap_hivec),
    .we(reg_we), .addr(reg_addr), .wdata(reg_wdata), .st(st), .rdata(reg_rdata)
  );

  vrm_decode #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE)) dec_i (
    .clk(clk), .rst(bus_rst), .addr(bus_addr), .remap(st.remap), .hivec(st.hivec),
    .rom_sel(rom_sel), .sram_sel(sram_sel), .other_sel(other_sel), .mem_addr(mem_addr)
  );

  assign vec_hi    = st.hivec;
  assign irq_cfg   = st.irq;
  assign remap_err = st.err;
endmodule

// File: tb/boot_remap_ctrl_tb_top.sv
module boot_remap_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        bus_rst = 1'b1, cold_rst = 1'b1, strap_hivec = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, bus_addr = '0;
  logic [31:0] reg_rdata, mem_addr;
  logic        rom_sel, sram_sel, other_sel, vec_hi, irq_cfg, remap_err;

  int checks = 0, fails = 0;
  logic m_remap = 0, m_hivec = 0, m_irq = 0, m_err = 0;

  always #10 clk = ~clk;

  boot_remap_ctrl dut_i (
    .clk(clk), .bus_rst(bus_rst), .cold_rst(cold_rst), .strap_hivec(strap_hivec),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bus_addr(bus_addr), .rom_sel(rom_sel), .sram_sel(sram_sel), .other_sel(other_sel),
    .mem_addr(mem_addr), .vec_hi(vec_hi), .irq_cfg(irq_cfg), .remap_err(remap_err)
  );

  function automatic logic [31:0] exp_rd(logic [3:0] a);
    case (a)
      4'h0:    return {30'b0, m_err, m_remap};
      4'h4:    return {31'b0, m_hivec};
      4'h8:    return {31'b0, m_irq};
      default: return 32'b0;
    endcase
  endfunction

  function automatic logic [2:0] exp_sel(logic [31:0] a);
    if (a >= 32'h8000) return 3'b001;
    return (m_remap && !m_hivec) ? 3'b010 : 3'b100;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    cyc();
    reg_we = 1'b0;
    if (a == 4'h0) begin
      if (d[0] && m_hivec) m_err = 1'b1; else m_remap = d[0];
    end else if (a == 4'h4) begin
      if (d[0] && m_remap) m_err = 1'b1; else m_hivec = d[0];
    end else if (a == 4'h8) m_irq = d[0];
  endtask

  task automatic rd_chk(logic [3:0] a, string req);
    reg_addr = a;
    cyc();
    chk(req, reg_rdata, exp_rd(a));
  endtask

  task automatic dec_chk(logic [31:0] a, string req);
    bus_addr = a;
    cyc();
    chk(req, {29'b0, rom_sel, sram_sel, other_sel}, {29'b0, exp_sel(a)});
    chk("R6 addr", mem_addr, a);
  endtask

  task automatic pins_chk();
    chk("R7 vec_hi", {31'b0, vec_hi}, {31'b0, m_hivec});
    chk("R7 irq_cfg", {31'b0, irq_cfg}, {31'b0, m_irq});
    chk("R8 err", {31'b0, remap_err}, {31'b0, m_err});
  endtask

  task automatic cold_pulse(logic s);
    strap_hivec = s; cold_rst = 1'b1;
    cyc();
    cold_rst = 1'b0;
    m_hivec = s; m_irq = 1'b0;
  endtask

  task automatic bus_pulse();
    bus_rst = 1'b1;
    cyc();
    chk("R1 sel in reset", {29'b0, rom_sel, sram_sel, other_sel}, 32'b0);
    chk("R1 rdata in reset", reg_rdata, 32'b0);
    bus_rst = 1'b0;
    m_remap = 1'b0; m_err = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    cyc(); cyc();
    chk("R1 reset sel", {29'b0, rom_sel, sram_sel, other_sel}, 32'b0);
    chk("R1 reset rdata", reg_rdata, 32'b0);
    bus_rst = 1'b0; cold_rst = 1'b0;
    pins_chk();
    // R4 boundaries, ROM after power-up
    dec_chk(32'h0000_0000, "R4 rom low");
    dec_chk(32'h0000_7FFF, "R4 rom top");
    dec_chk(32'h0000_8000, "R6 edge out");
    dec_chk(32'hFFFF_0000, "R6 high out");
    // R10: same-cycle address still sees the old remap
    reg_we = 1'b1; reg_addr = 4'h0; reg_wdata = 32'h1; bus_addr = 32'h100;
    cyc();
    reg_we = 1'b0; m_remap = 1'b1;
    chk("R10 old value", {29'b0, rom_sel, sram_sel, other_sel}, 32'h4);
    cyc();
    chk("R10 new value", {29'b0, rom_sel, sram_sel, other_sel}, 32'h2);
    dec_chk(32'h0000_7FFF, "R5 sram");
    // R9 map
    rd_chk(4'h0, "R9 remap rd");
    rd_chk(4'hC, "R9 unused off");
    wr(4'hC, 32'hFFFF_FFFF);
    rd_chk(4'h0, "R9 wr unused no effect");
    wr(4'h8, 32'hFFFF_FFFF);
    rd_chk(4'h8, "R9 irq rd");
    pins_chk();
    // R8: high-vector refused while remap set
    wr(4'h4, 32'h1);
    rd_chk(4'h4, "R8 hivec refused");
    rd_chk(4'h0, "R8 err flag");
    pins_chk();
    // R3, R11: cold reset with strap high keeps remap
    cold_pulse(1'b1);
    rd_chk(4'h0, "R3 remap kept");
    rd_chk(4'h8, "R2 irq cleared");
    pins_chk();
    dec_chk(32'h0000_0040, "R11 forbidden pair to rom");
    wr(4'h0, 32'h1);
    rd_chk(4'h0, "R8 remap refused");
    // R2: bus reset keeps hivec, clears remap/err
    bus_pulse();
    rd_chk(4'h4, "R2 hivec kept");
    rd_chk(4'h0, "R1 remap cleared");
    pins_chk();
    cold_pulse(1'b0);
    pins_chk();
    // random phase
    for (int i = 0; i < 600; i++) begin
      int unsigned op = $urandom % 10;
      if (op < 3) begin
        logic [3:0] a = ($urandom % 2) ? 4'(($urandom % 4) * 4) : 4'($urandom);
        wr(a, $urandom);
      end else if (op < 5) begin
        rd_chk(4'(($urandom % 4) * 4), "R9 rand read");
      end else if (op < 9) begin
        dec_chk(($urandom % 2) ? ($urandom % 32'h9000) : $urandom, "R4 R5 R6 rand decode");
      end else if ($urandom % 3 == 0) begin
        cold_pulse(1'($urandom));
      end else begin
        bus_pulse();
      end
      pins_chk();
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule